// File: doc/BRIEF.md
# Hashed Page Table Walker

This block handles a translation miss by searching a page table that sits in ordinary memory. A request carries a 24-bit virtual segment identifier and a 16-bit page index, which is the upper part of the 28-bit offset inside the segment; the low 12 bits address a byte within a 4 KB page. The walker hashes the request, turns the hash into the address of a 64-byte group of eight 8-byte entries, and reads those entries one at a time. It compares each entry against the request. If the first group has no match, it searches a second group found through the complemented hash. It reports either the physical page number or a page fault.

The request side and both memory channels are valid/ready streams. A transfer takes place on a clock edge where valid and ready are both high. A source that has raised valid keeps it high, with its payload stable, until that edge. The walker accepts a request only when it is idle, and it holds `req_ready` low from acceptance up to and including the cycle of the done pulse. Only one memory read is in flight at a time. The read address stays stable while `mem_req_ready` is low, and `mem_rsp_ready` is high only while the walker waits for the data of that read. `busy`, `done` and the result pins are plain status signals.

`cfg_table` holds the table origin in bits [31:16] and a 9-bit size mask in bits [8:0]. The origin must be aligned to the table size.

Top module: `hpt_walker`

## Requirements
- R1: After reset `req_ready` is 1, and `busy`, `done` and `mem_req_valid` are all 0.
- R2: The primary hash is the low 19 bits of the segment identifier XOR the zero-extended page index. The group address is `{cfg_table[31:16],16'h0}` plus the hash shifted left by 6, where hash bits [18:10] are first ANDed with `cfg_table[8:0]`.
- R3: Inside a group, the entries are read in the order 0 to 7, at the group address plus 8 times the entry number, so every read address is 8-byte aligned.
- R4: An entry is 64 bits. Bit 63 is valid, bits [62:39] are the segment identifier, bit 38 is the hash select, bits [37:32] are the abbreviated page index (page index bits [15:10]) and bits [31:12] are the physical page number. The entry matches only when it is valid, the identifier and abbreviated index are equal to the request, and the hash select is 0 in the primary group or 1 in the secondary group.
- R5: The search stops at the first matching entry. It then pulses `done` with `done_hit`=1, `done_fault`=0, and that entry's page number on `done_ppn`.
- R6: After eight misses in the primary group, the walker searches the secondary group, whose address comes from the one's complement of the primary hash.
- R7: When both groups miss, exactly 16 reads have been made and `done` pulses with `done_fault`=1 and `done_hit`=0.
- R8: While a walk is in progress, new requests are held off. `done` is high for one cycle, and in the next cycle `req_ready` is 1 again.
- R9: A stalled read request keeps its address stable, no new read is issued while a response is awaited, and back-pressure does not change the result.
- R10: With a narrow size mask, hash bits [18:10] are cut down to the mask, so every read falls inside the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_table | input | 32 | Table origin [31:16], size mask [8:0] |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle, can accept a request |
| req_vsid | input | 24 | Virtual segment identifier |
| req_pidx | input | 16 | Page index within the segment |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Read address valid |
| mem_req_ready | input | 1 | Memory accepts the read address |
| mem_req_addr | output | 32 | Byte address of the entry to read |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_ready | output | 1 | Walker waiting for read data |
| mem_rsp_data | input | 64 | Entry read from memory |
| done | output | 1 | One-cycle end-of-walk pulse |
| done_hit | output | 1 | Walk found a match (with done) |
| done_fault | output | 1 | Both groups missed (with done) |
| done_ppn | output | 20 | Physical page number on a hit |

## Verification
Two events can meet in one cycle: a new request arriving and the done pulse of the walk still running. The bench provokes this by holding `req_valid` high across a whole walk. It then requires that the done cycle still shows `req_ready` low, that the waiting request is taken in the very next cycle, and that the second walk reports its own result. The other such meeting is a miss on entry 7 of the primary group, where the same response closes the first group and opens the second. This case is judged from the logged read addresses.

// File: rtl/hpt_pkg.sv
package hpt_pkg;
  localparam int VSID_W = 24;
  localparam int PIDX_W = 16;
  localparam int API_W  = 6;
  localparam int PPN_W  = 20;
  localparam int ADDR_W = 32;
  localparam int ENT_W  = 64;

  typedef struct packed {
    logic              valid;
    logic [VSID_W-1:0] vsid;
    logic              hsel;
    logic [API_W-1:0]  api;
    logic [PPN_W-1:0]  ppn;
    logic [11:0]       spare;
  } pte_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ISSUE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_DONE  = 2'd3
  } walk_st_e;
endpackage

// File: rtl/hpt_group_addr.sv
module hpt_group_addr #(
  parameter int VSID_W    = 24,
  parameter int PIDX_W    = 16,
  parameter int HASH_W    = 19,
  parameter int MASK_W    = 9,
  parameter int ADDR_W    = 32,
  parameter int GRP_SHIFT = 6
) (
  input  logic [VSID_W-1:0] vsid,
  input  logic [PIDX_W-1:0] pidx,
  input  logic              sec,
  input  logic [ADDR_W-1:0] cfg_table,
  output logic [ADDR_W-1:0] grp_addr
);
  localparam int LOW_W    = HASH_W - MASK_W;
  localparam int BASE_LSB = LOW_W + GRP_SHIFT;
  localparam int PAD_W    = ADDR_W - HASH_W - GRP_SHIFT;

  logic [HASH_W-1:0] h_pri;
  logic [HASH_W-1:0] h_sel;
  logic [HASH_W-1:0] h_msk;
  logic [ADDR_W-1:0] base;
  logic [ADDR_W-1:0] offs;

  assign h_pri = vsid[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, pidx};
  assign h_sel = sec ? ~h_pri : h_pri;

  // low hash bits always index the table; upper bits are gated by size mask
  assign h_msk[LOW_W-1:0] = h_sel[LOW_W-1:0];
  generate
    for (genvar b = 0; b < MASK_W; b++) begin : g_mask
      assign h_msk[LOW_W+b] = h_sel[LOW_W+b] & cfg_table[b];
    end
  endgenerate

  assign base     = {cfg_table[ADDR_W-1:BASE_LSB], {BASE_LSB{1'b0}}};
  assign offs     = {{PAD_W{1'b0}}, h_msk, {GRP_SHIFT{1'b0}}};
  assign grp_addr = base + offs;
endmodule

// File: rtl/hpt_pte_match.sv
module hpt_pte_match
  import hpt_pkg::*;
(
  input  logic [ENT_W-1:0]  raw,
  input  logic [VSID_W-1:0] vsid,
  input  logic [API_W-1:0]  api,
  input  logic              sec,
  output logic              hit,
  output logic [PPN_W-1:0]  ppn
);
  pte_t e;
  assign e   = pte_t'(raw);
  assign hit = e.valid && (e.vsid == vsid) && (e.api == api) && (e.hsel == sec);
  assign ppn = e.ppn;
endmodule

// File: rtl/hpt_walk_seq.sv
module hpt_walk_seq
  import hpt_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VSID_W-1:0] req_vsid,
  input  logic [PIDX_W-1:0] req_pidx,
  output logic [VSID_W-1:0] cur_vsid,
  output logic [PIDX_W-1:0] cur_pidx,
  output logic              sec,
  output logic [IDX_W-1:0]  idx,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic              ent_hit,
  input  logic [PPN_W-1:0]  ent_ppn,
  output logic              busy,
  output logic              done,
  output logic              done_hit,
  output logic              done_fault,
  output logic [PPN_W-1:0]  done_ppn
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

  walk_st_e st;
  logic     hit_q;
  logic     fault_q;
  logic [PPN_W-1:0] ppn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      idx      <= '0;
      sec      <= 1'b0;
      cur_vsid <= '0;
      cur_pidx <= '0;
      hit_q    <= 1'b0;
      fault_q  <= 1'b0;
      ppn_q    <= '0;
    end else begin
      case (st)
        ST_IDLE: if (req_valid) begin
          cur_vsid <= req_vsid;
          cur_pidx <= req_pidx;
          idx      <= '0;
          sec      <= 1'b0;
          hit_q    <= 1'b0;
          fault_q  <= 1'b0;
          ppn_q    <= '0;
          st       <= ST_ISSUE;
        end
        ST_ISSUE: if (mem_req_ready) st <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          if (ent_hit) begin
            hit_q <= 1'b1;
            ppn_q <= ent_ppn;
            st    <= ST_DONE;
          end else if (idx == LAST) begin
            if (sec) begin
              fault_q <= 1'b1;
              st      <= ST_DONE;
            end else begin
              sec <= 1'b1;
              idx <= '0;
              st  <= ST_ISSUE;
            end
          end else begin
            idx <= idx + 1'b1;
            st  <= ST_ISSUE;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (st == ST_IDLE);
  assign busy          = (st != ST_IDLE);
  assign mem_req_valid = (st == ST_ISSUE);
  assign mem_rsp_ready = (st == ST_WAIT);
  assign done          = (st == ST_DONE);
  assign done_hit      = done & hit_q;
  assign done_fault    = done & fault_q;
  assign done_ppn      = ppn_q;
endmodule

// File: rtl/hpt_walker.sv
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int ENTRIES     = 8,
  parameter int ENTRY_BYTES = 8,
  parameter int HASH_W      = 19,
  parameter int MASK_W      = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cfg_table,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [VSID_W-1:0] req_vsid,
  input  logic [PIDX_W-1:0] req_pidx,
  output logic              busy,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  output logic              mem_rsp_ready,
  input  logic [ENT_W-1:0]  mem_rsp_data,
  output logic              done,
  output logic              done_hit,
  output logic              done_fault,
  output logic [PPN_W-1:0]  done_ppn
);
  localparam int IDX_W     = $clog2(ENTRIES);
  localparam int ENT_SHIFT = $clog2(ENTRY_BYTES);
  localparam int GRP_SHIFT = IDX_W + ENT_SHIFT;

  logic [VSID_W-1:0] cur_vsid;
  logic [PIDX_W-1:0] cur_pidx;
  logic              sec;
  logic [IDX_W-1:0]  idx;
  logic [ADDR_W-1:0] grp_addr;
  logic              ent_hit;
  logic [PPN_W-1:0]  ent_ppn;

  hpt_walk_seq #(.ENTRIES(ENTRIES)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vsid(req_vsid), .req_pidx(req_pidx),
    .cur_vsid(cur_vsid), .cur_pidx(cur_pidx), .sec(sec), .idx(idx),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready),
    .ent_hit(ent_hit), .ent_ppn(ent_ppn),
    .busy(busy), .done(done), .done_hit(done_hit),
    .done_fault(done_fault), .done_ppn(done_ppn)
  );

  hpt_group_addr #(
    .VSID_W(VSID_W), .PIDX_W(PIDX_W), .HASH_W(HASH_W),
    .MASK_W(MASK_W), .ADDR_W(ADDR_W), .GRP_SHIFT(GRP_SHIFT)
  ) u_addr (
    .vsid(cur_vsid), .pidx(cur_pidx), .sec(sec),
    .cfg_table(cfg_table), .grp_addr(grp_addr)
  );

  hpt_pte_match u_match (
    .raw(mem_rsp_data), .vsid(cur_vsid),
    .api(cur_pidx[PIDX_W-1 -: API_W]), .sec(sec),
    .hit(ent_hit), .ppn(ent_ppn)
  );

  assign mem_req_addr = grp_addr +
    {{(ADDR_W-IDX_W-ENT_SHIFT){1'b0}}, idx, {ENT_SHIFT{1'b0}}};
endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int ENTRIES = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        busy,
  input logic        mem_req_valid,
  input logic        mem_req_ready,
  input logic [31:0] mem_req_addr,
  input logic        mem_rsp_ready,
  input logic        done,
  input logic        done_hit,
  input logic        done_fault
);
  localparam int MAX_RD = 2 * ENTRIES;
  localparam int CNT_W  = $clog2(MAX_RD + 1);

  logic [CNT_W-1:0] rd_cnt;
  always_ff @(posedge clk) begin
    if (!rst_n) rd_cnt <= '0;
    else if (req_valid && req_ready) rd_cnt <= '0;
    else if (mem_req_valid && mem_req_ready) rd_cnt <= rd_cnt + 1'b1;
  end

  p_after_reset_r1: assert property (@(posedge clk) $rose(rst_n) |-> req_ready && !done);
  p_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> (mem_req_addr[2:0] == 3'b000));
  p_one_outcome_r5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({done_hit, done_fault}) == 1));
  p_read_budget_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_cnt <= CNT_W'(MAX_RD));
  p_fault_reads_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_fault |-> (rd_cnt == CNT_W'(MAX_RD)));
  p_accept_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> busy);
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_ready_after_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready);
  p_addr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> mem_req_valid && $stable(mem_req_addr));
  p_one_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rsp_ready |-> !mem_req_valid);
endmodule

bind hpt_walker hpt_walker_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .busy(busy), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_ready(mem_rsp_ready),
  .done(done), .done_hit(done_hit), .done_fault(done_fault)
);

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_table = 32'h0200_01FF;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [23:0] req_vsid = '0;
  logic [15:0] req_pidx = '0;
  logic        busy;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        done, done_hit, done_fault;
  logic [19:0] done_ppn;

  hpt_walker u_hpt_walker (
    .clk(clk), .rst_n(rst_n), .cfg_table(cfg_table),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vsid(req_vsid), .req_pidx(req_pidx), .busy(busy),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .done(done), .done_hit(done_hit), .done_fault(done_fault),
    .done_ppn(done_ppn)
  );

  always #2 clk = ~clk;

  int total = 0;
  int bad = 0;
  logic [63:0] mem [int unsigned];
  int unsigned log_a [0:31];
  int log_n = 0;
  bit stall = 0;
  bit pend = 0, clr = 0;
  int unsigned pend_a = 0;
  int res_n = 0;
  logic r_hit = 0, r_fault = 0;
  logic [19:0] r_ppn = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] mk(input bit v, input logic [23:0] vs, input bit h,
                                     input logic [5:0] api, input logic [19:0] ppn);
    return {v, vs, h, api, ppn, 12'h000};
  endfunction

  function automatic int unsigned grp(input logic [23:0] vs, input logic [15:0] pi,
                                      input bit s, input logic [31:0] cfg);
    logic [18:0] h;
    logic [18:0] m;
    h = vs[18:0] ^ {3'b000, pi};
    if (s) h = ~h;
    m = {h[18:10] & cfg[8:0], h[9:0]};
    return {cfg[31:16], 16'h0000} + {7'b0, m, 6'b0};
  endfunction

  // memory model and result capture, all away from the active edge
  always @(negedge clk) begin
    if (clr) begin mem_rsp_valid = 1'b0; clr = 0; end
    if (pend && !mem_rsp_valid) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data = mem.exists(pend_a) ? mem[pend_a] : 64'h0;
      pend = 0;
    end
    if (mem_rsp_valid && mem_rsp_ready) clr = 1;
    mem_req_ready = stall ? ~mem_req_ready : rst_n;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      pend = 1; pend_a = mem_req_addr;
      if (log_n < 32) log_a[log_n] = mem_req_addr;
      log_n++;
    end
    if (done) begin
      res_n++; r_hit = done_hit; r_fault = done_fault; r_ppn = done_ppn;
    end
  end

  task automatic walk(input logic [23:0] vs, input logic [15:0] pi);
    log_n = 0; res_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vsid = vs; req_pidx = pi;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 400 && res_n == 0; i++) @(negedge clk);
    chk(res_n == 1, "R8 walk completion", res_n, 1);
  endtask

  task automatic chk_reads(input string tag, input int n, input logic [23:0] vs,
                           input logic [15:0] pi, input logic [31:0] cfg);
    chk(log_n == n, {tag, " read count"}, log_n, n);
    for (int i = 0; i < n && i < log_n; i++) begin
      int unsigned e;
      e = grp(vs, pi, i >= 8, cfg) + 8 * (i % 8);
      chk(log_a[i] == e, {tag, " read address"}, log_a[i], e);
    end
  endtask

  task automatic t_reset;
    chk(req_ready == 1'b1, "R1 req_ready", req_ready, 1);
    chk(busy == 1'b0, "R1 busy", busy, 0);
    chk(done == 1'b0, "R1 done", done, 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", mem_req_valid, 0);
  endtask

  task automatic t_primary_hit(input string tag);
    logic [23:0] vs = 24'hA5_1234;
    logic [15:0] pi = 16'hBEEF;
    int unsigned g;
    mem.delete();
    g = grp(vs, pi, 0, cfg_table);
    mem[g + 0]  = mk(0, vs, 0, pi[15:10], 20'h11111);
    mem[g + 8]  = mk(1, vs ^ 24'h1, 0, pi[15:10], 20'h22222);
    mem[g + 16] = mk(1, vs, 0, pi[15:10] ^ 6'h1, 20'h33333);
    mem[g + 24] = mk(1, vs, 0, pi[15:10], 20'h12345);
    walk(vs, pi);
    chk_reads({tag, " R2 R3"}, 4, vs, pi, cfg_table);
    chk(r_hit == 1 && r_fault == 0, {tag, " R4 hit flag"}, {r_hit, r_fault}, 2'b10);
    chk(r_ppn == 20'h12345, {tag, " R5 ppn"}, r_ppn, 20'h12345);
  endtask

  task automatic t_secondary_hit;
    logic [23:0] vs = 24'h3C_0F0F;
    logic [15:0] pi = 16'h1234;
    int unsigned gp, gs;
    mem.delete();
    gp = grp(vs, pi, 0, cfg_table);
    gs = grp(vs, pi, 1, cfg_table);
    mem[gp + 32] = mk(1, vs, 1, pi[15:10], 20'hBAD00);
    mem[gs + 40] = mk(1, vs, 1, pi[15:10], 20'h5A5A5);
    walk(vs, pi);
    chk_reads("R6 secondary", 14, vs, pi, cfg_table);
    chk(r_hit == 1, "R4 R6 secondary hit", r_hit, 1);
    chk(r_ppn == 20'h5A5A5, "R6 secondary ppn", r_ppn, 20'h5A5A5);
  endtask

  task automatic t_fault;
    logic [23:0] vs = 24'h00_7777;
    logic [15:0] pi = 16'h8001;
    int unsigned gs;
    mem.delete();
    gs = grp(vs, pi, 1, cfg_table);
    mem[gs + 0] = mk(1, vs, 0, pi[15:10], 20'hDEAD0);
    walk(vs, pi);
    chk_reads("R7 fault", 16, vs, pi, cfg_table);
    chk(r_fault == 1 && r_hit == 0, "R7 fault flags", {r_hit, r_fault}, 2'b01);
  endtask

  task automatic t_first_match;
    logic [23:0] vs = 24'h12_3456;
    logic [15:0] pi = 16'h4321;
    int unsigned g;
    mem.delete();
    g = grp(vs, pi, 0, cfg_table);
    mem[g + 16] = mk(1, vs, 0, pi[15:10], 20'hAAAAA);
    mem[g + 48] = mk(1, vs, 0, pi[15:10], 20'hBBBBB);
    walk(vs, pi);
    chk(log_n == 3, "R5 stop at first match reads", log_n, 3);
    chk(r_ppn == 20'hAAAAA, "R5 first match ppn", r_ppn, 20'hAAAAA);
  endtask

  task automatic t_mask;
    logic [23:0] vs = 24'h07_C000;
    logic [15:0] pi = 16'h0001;
    int unsigned g;
    cfg_table = 32'h0034_0003;
    mem.delete();
    g = grp(vs, pi, 0, cfg_table);
    mem[g] = mk(1, vs, 0, pi[15:10], 20'h0F00D);
    walk(vs, pi);
    chk_reads("R10 masked", 1, vs, pi, cfg_table);
    chk(log_a[0] >= 32'h0034_0000 && log_a[0] < 32'h0038_0000,
        "R10 within table", log_a[0], 32'h0034_0000);
    chk(r_ppn == 20'h0F00D, "R10 masked ppn", r_ppn, 20'h0F00D);
    cfg_table = 32'h0200_01FF;
  endtask

  task automatic t_busy;
    logic [23:0] vs = 24'h44_4444;
    logic [15:0] pi = 16'h0400;
    int acc = 0, dn = 0;
    bit prev_done = 0, saw_overlap = 0;
    mem.delete();
    mem[grp(vs, pi, 0, cfg_table)] = mk(1, vs, 0, pi[15:10], 20'h77777);
    @(negedge clk);
    req_valid = 1'b1; req_vsid = vs; req_pidx = pi;
    for (int i = 0; i < 300 && acc < 2; i++) begin
      if (done) begin
        dn++;
        chk(req_ready == 1'b0, "R8 held off in done cycle", req_ready, 0);
      end
      if (req_valid && req_ready) begin
        acc++;
        if (acc == 2) saw_overlap = prev_done;
      end
      prev_done = done;
      if (acc < 2) @(negedge clk);
    end
    chk(acc == 2 && dn == 1, "R8 one accept per walk", acc, 2);
    chk(saw_overlap, "R8 ready right after done", saw_overlap, 1);
    res_n = 0;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 200 && res_n == 0; i++) @(negedge clk);
    @(negedge clk);
    chk(res_n == 1 && r_ppn == 20'h77777, "R8 second walk result", r_ppn, 20'h77777);
    chk(done == 1'b0, "R8 done single pulse", done, 0);
  endtask

  initial begin
    #(4 * 150000);
    bad++; total++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_primary_hit("base");
    t_secondary_hit();
    t_fault();
    t_first_match();
    t_mask();
    stall = 1;
    t_primary_hit("R9 backpressure");
    stall = 0;
    t_busy();
    repeat (4) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule